// File: doc/BRIEF.md
# Spread-Spectrum Feedback Modulator

This block sits in front of the fractional feedback input of a fractional-N synthesizer and sweeps that feedback value slowly up and down, which spreads the output clock energy over a narrow band and lowers the peak emission. A slow reference tick steps a 128-point triangle profile. The current profile point is scaled by a programmed amplitude and a fraction of the nominal feedback value, and the result is added to the feedback value as a fractional offset. The sweep can be centred on the nominal value or kept entirely below it.

Software programs a single 16-bit control word. Each write carries a per-bit enable in its upper halfword. The intended bring-up order is as follows. First set the sweep shape, the amplitude and the step divider. Next clear the bypass and stop bits. Then pulse the generator's restart bit high and low. Shape, amplitude and divider may be changed while the sweep runs, and the change takes effect without restarting the profile. The sweep only keeps the mean frequency unchanged when the nominal fractional part is zero, so the offset is applied only in that case.

Top module: `ssc_modulator`

## Requirements
- R1: After the synchronous reset `rst` the control word is 0x0007, with bypass, stop and restart all set and every other bit zero. The output then equals the nominal feedback value `{fb_int, fb_frac}`.
- R2: A write sets `ctrl <= (ctrl & ~wr_data[31:16]) | (wr_data[15:0] & wr_data[31:16])`, so a low-half bit whose enable bit is 0 keeps its value.
- R3: Control bit 0 is bypass and bit 1 is stop. When either is 1 the output equals the nominal value and the profile index does not move.
- R4: Control bit 2 is restart. While it is 1 the profile index and the step counter are held at 0 and the offset is 0. Once it is cleared the sweep starts from index 0.
- R5: Bits 7:4 are the step divider D. The index advances by one for every D accepted ticks, and a D of 0 acts as 1.
- R6: The index wraps from 127 to 0.
- R7: The profile level L is the index for indices 0..63 and 127 minus the index for indices 64..127.
- R8: With bit 3 at 0 (centred), the offset is (2L-63)*A*F/63000, truncated toward zero. A is bits 12:8 and F is the nominal value in units of 2^-24.
- R9: With bit 3 at 1 (downward), the offset is (L-63)*A*F/63000, truncated toward zero, and it is never positive.
- R10: An amplitude of 0 gives an output equal to the nominal value.
- R11: A nonzero `fb_frac` suppresses the offset, so the output equals the nominal value.
- R12: The output is registered. It reflects inputs and state one clock later.
- R13: A change of amplitude, shape or divider while the sweep runs takes effect on the next output without resetting the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse per divided reference period |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 32 | Upper half per-bit enables, lower half new control bits |
| fb_int | input | INT_W (12) | Nominal integer feedback divider |
| fb_frac | input | FRAC_W (24) | Nominal fractional feedback divider |
| fb_out_int | output | INT_W (12) | Modulated integer feedback |
| fb_out_frac | output | FRAC_W (24) | Modulated fractional feedback |

## Verification
The bench builds the block with its default parameters: a 12-bit integer part, a 24-bit fraction and a 7-bit profile index. With these values a full 128-point period at divider 1 takes only a few hundred cycles, so the bench reaches the wrap from 127 to 0, the peak at index 63 and the first falling point at index 64. The 36-bit feedback word also keeps the full product of level, amplitude and feedback value within 64-bit bench arithmetic. That lets the bench model truncation toward zero for negative offsets exactly.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    localparam int CTRL_W  = 13;
    localparam int AMP_W   = 5;
    localparam int RATE_W  = 4;
    localparam int PERMILLE = 1000;

    // control word, bit positions fixed by the register layout
    typedef struct packed {
        logic [AMP_W-1:0]  amp;     // 12:8
        logic [RATE_W-1:0] rate;    // 7:4
        logic              down;    // 3
        logic              restart; // 2
        logic              stop;    // 1
        logic              bypass;  // 0
    } ctrl_t;

    localparam logic [CTRL_W-1:0] CTRL_RST = 13'h0007;

    function automatic logic [RATE_W-1:0] rate_last(input logic [RATE_W-1:0] r);
        return (r == '0) ? '0 : r - 1'b1;
    endfunction

endpackage

// File: rtl/ssc_ctrl_reg.sv
module ssc_ctrl_reg
    import ssc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output ctrl_t       ctrl
);

    logic [CTRL_W-1:0] q;
    logic [CTRL_W-1:0] mask;
    logic [CTRL_W-1:0] data;
    logic              rsvd_unused;

    assign mask        = wr_data[16 +: CTRL_W];
    assign data        = wr_data[CTRL_W-1:0];
    assign rsvd_unused = ^{wr_data[31:16+CTRL_W], wr_data[15:CTRL_W]};

    always_ff @(posedge clk) begin
        if (rst)
            q <= CTRL_RST;
        else if (wr_en)
            q <= (q & ~mask) | (data & mask);
    end

    assign ctrl = ctrl_t'(q);

    p_masked_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[31:16] == 16'h0) |=> $stable(q));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(q));

endmodule

// File: rtl/ssc_rate_gen.sv
module ssc_rate_gen
    import ssc_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              run,
    input  logic              restart,
    input  logic [RATE_W-1:0] rate,
    output logic [IDX_W-1:0]  idx
);

    logic [RATE_W-1:0] cnt;
    logic [RATE_W-1:0] last;

    assign last = rate_last(rate);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
            idx <= '0;
        end else if (run && ref_tick) begin
            if (cnt >= last) begin
                cnt <= '0;
                idx <= idx + 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    p_hold_restart_r4: assert property (@(posedge clk) disable iff (rst)
        restart |=> (idx == '0 && cnt == '0));

    p_single_step_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(idx) |-> (idx == '0 || idx == IDX_W'($past(idx) + 1'b1)));

    p_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(idx));

    p_no_tick_r5: assert property (@(posedge clk) disable iff (rst)
        (!ref_tick && !restart) |=> $stable(idx));

endmodule

// File: rtl/ssc_profile.sv
module ssc_profile
    import ssc_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int FB_W  = 36
) (
    input  logic [IDX_W-1:0]   idx,
    input  logic [AMP_W-1:0]   amp,
    input  logic               down,
    input  logic [FB_W-1:0]    fb,
    output logic signed [FB_W:0] offset
);

    localparam int LVL_W  = IDX_W - 1;
    localparam int PEAK   = (1 << LVL_W) - 1;
    localparam int DEN    = PEAK * PERMILLE;
    localparam int PROD_W = IDX_W + AMP_W + FB_W;

    logic [LVL_W-1:0]  lvl;
    logic [IDX_W-1:0]  twice;
    logic [IDX_W-1:0]  mag;
    logic              neg;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quo;
    logic [FB_W:0]     quo_t;

    // rising half uses the index, falling half its complement
    assign lvl   = idx[IDX_W-1] ? ~idx[LVL_W-1:0] : idx[LVL_W-1:0];
    assign twice = {lvl, 1'b0};

    always_comb begin
        if (down) begin
            neg = 1'b1;
            mag = IDX_W'(PEAK) - IDX_W'(lvl);
        end else if (twice >= IDX_W'(PEAK)) begin
            neg = 1'b0;
            mag = twice - IDX_W'(PEAK);
        end else begin
            neg = 1'b1;
            mag = IDX_W'(PEAK) - twice;
        end
    end

    assign prod   = PROD_W'(mag) * PROD_W'(amp) * PROD_W'(fb);
    assign quo    = prod / PROD_W'(DEN);
    assign quo_t  = (FB_W+1)'(quo);
    assign offset = neg ? -$signed(quo_t) : $signed(quo_t);

endmodule

// File: rtl/ssc_modulator.sv
module ssc_modulator
    import ssc_pkg::*;
#(
    parameter int INT_W  = 12,
    parameter int FRAC_W = 24,
    parameter int IDX_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic [INT_W-1:0]  fb_int,
    input  logic [FRAC_W-1:0] fb_frac,
    output logic [INT_W-1:0]  fb_out_int,
    output logic [FRAC_W-1:0] fb_out_frac
);

    localparam int FB_W = INT_W + FRAC_W;

    ctrl_t               ctrl;
    logic [IDX_W-1:0]    idx;
    logic [FB_W-1:0]     nom;
    logic signed [FB_W:0] offset;
    logic signed [FB_W:0] sum;
    logic                active;
    logic                apply;
    logic [FB_W-1:0]     out_q;

    assign nom    = {fb_int, fb_frac};
    assign active = !ctrl.bypass && !ctrl.stop;
    assign apply  = active && !ctrl.restart && (fb_frac == '0);

    ssc_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl)
    );

    ssc_rate_gen #(.IDX_W(IDX_W)) u_rate (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .run      (active),
        .restart  (ctrl.restart),
        .rate     (ctrl.rate),
        .idx      (idx)
    );

    ssc_profile #(.IDX_W(IDX_W), .FB_W(FB_W)) u_prof (
        .idx    (idx),
        .amp    (ctrl.amp),
        .down   (ctrl.down),
        .fb     (nom),
        .offset (offset)
    );

    assign sum = $signed({1'b0, nom}) + offset;

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= '0;
        else if (apply)
            out_q <= FB_W'(sum);
        else
            out_q <= nom;
    end

    assign fb_out_int  = out_q[FB_W-1:FRAC_W];
    assign fb_out_frac = out_q[FRAC_W-1:0];

    p_pass_through_r3: assert property (@(posedge clk) disable iff (rst)
        !active |=> out_q == $past(nom));

    p_restart_zero_r4: assert property (@(posedge clk) disable iff (rst)
        ctrl.restart |=> out_q == $past(nom));

    p_amp_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (ctrl.amp == '0) |=> out_q == $past(nom));

    p_frac_gate_r11: assert property (@(posedge clk) disable iff (rst)
        (fb_frac != '0) |=> out_q == $past(nom));

    p_down_below_r9: assert property (@(posedge clk) disable iff (rst)
        ctrl.down |=> out_q <= $past(nom));

endmodule

// File: tb/ssc_modulator_test.sv
module ssc_modulator_test;

    localparam int INT_W  = 12;
    localparam int FRAC_W = 24;
    localparam int IDX_W  = 7;

    logic              clk = 1'b0;
    logic              rst;
    logic              ref_tick;
    logic              wr_en;
    logic [31:0]       wr_data;
    logic [INT_W-1:0]  fb_int;
    logic [FRAC_W-1:0] fb_frac;
    logic [INT_W-1:0]  fb_out_int;
    logic [FRAC_W-1:0] fb_out_frac;

    int          errors = 0;
    int          checks = 0;
    bit          done   = 0;
    logic [15:0] m_ctrl;
    int          m_idx;
    int          m_cnt;

    always #5 clk = ~clk;

    ssc_modulator #(.INT_W(INT_W), .FRAC_W(FRAC_W), .IDX_W(IDX_W)) uut (
        .clk         (clk),
        .rst         (rst),
        .ref_tick    (ref_tick),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .fb_int      (fb_int),
        .fb_frac     (fb_frac),
        .fb_out_int  (fb_out_int),
        .fb_out_frac (fb_out_frac)
    );

    function automatic longint nominal();
        return (longint'(fb_int) << FRAC_W) | longint'(fb_frac);
    endfunction

    function automatic longint expect_out();
        longint f = nominal();
        int lvl, s, a;
        if (m_ctrl[0] || m_ctrl[1] || m_ctrl[2] || fb_frac != 0) return f;
        lvl = (m_idx < 64) ? m_idx : 127 - m_idx;
        s   = m_ctrl[3] ? lvl - 63 : 2 * lvl - 63;
        a   = int'(m_ctrl[12:8]);
        return f + (longint'(s) * a * f) / 63000;
    endfunction

    function automatic longint got_out();
        return (longint'(fb_out_int) << FRAC_W) | longint'(fb_out_frac);
    endfunction

    task automatic check_val(input string req, input longint got, input longint exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req);
        settle();
        check_val(req, got_out(), expect_out());
    endtask

    task automatic wr(input logic [15:0] mask, input logic [15:0] data);
        wr_en   = 1'b1;
        wr_data = {mask, data};
        @(negedge clk);
        wr_en   = 1'b0;
        m_ctrl  = (m_ctrl & ~mask) | (data & mask);
        if (m_ctrl[2]) begin
            m_idx = 0;
            m_cnt = 0;
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            int lim;
            ref_tick = 1'b1;
            @(negedge clk);
            if (m_ctrl[2]) begin
                m_idx = 0;
                m_cnt = 0;
            end else if (!m_ctrl[0] && !m_ctrl[1]) begin
                lim = (m_ctrl[7:4] == 0) ? 1 : int'(m_ctrl[7:4]);
                if (m_cnt >= lim - 1) begin
                    m_cnt = 0;
                    m_idx = (m_idx + 1) % 128;
                end else begin
                    m_cnt++;
                end
            end
        end
        ref_tick = 1'b0;
    endtask

    // R1, R12: reset state and one-cycle output latency
    task automatic t_reset();
        rst = 1'b1; ref_tick = 1'b0; wr_en = 1'b0; wr_data = '0;
        fb_int = 12'd100; fb_frac = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_ctrl = 16'h0007; m_idx = 0; m_cnt = 0;
        chk("R1");
        fb_int = 12'd200;
        #1;
        check_val("R12", got_out(), longint'(100) << FRAC_W);
        chk("R12");
    endtask

    // R2, R3, R8: masked programming and start-up
    task automatic t_config();
        wr(16'h1ff8, 16'h0810);
        chk("R2");
        wr(16'h0007, 16'h0000);
        chk("R8");
        check_val("R8", got_out(), (longint'(200) << FRAC_W) - ((longint'(200) << FRAC_W) * 8) / 1000);
        wr(16'h0000, 16'h1f07);
        chk("R2");
        wr(16'h0002, 16'hffff);
        chk("R3");
        wr(16'h0002, 16'h0000);
        chk("R2");
    endtask

    // R7, R8: centred profile over rising and falling halves
    task automatic t_center();
        tick(32); chk("R7");
        tick(31); chk("R8");
        tick(1);  chk("R7");
        tick(40); chk("R7");
    endtask

    // R6: wrap of the index
    task automatic t_wrap();
        tick(24); chk("R6");
        tick(1);  chk("R6");
    endtask

    // R3: bypass freezes the index and passes the nominal value
    task automatic t_bypass();
        wr(16'h0001, 16'h0001);
        chk("R3");
        tick(5);
        chk("R3");
        wr(16'h0001, 16'h0000);
        chk("R3");
    endtask

    // R5, R13: step divider including the zero case and a live change
    task automatic t_rate();
        wr(16'h00f0, 16'h0030);
        tick(7); chk("R5");
        tick(2); chk("R5");
        wr(16'h00f0, 16'h0000);
        tick(3); chk("R13");
    endtask

    // R9, R13: downward profile and shape change while running
    task automatic t_down();
        wr(16'h0008, 16'h0008);
        chk("R13");
        tick(20); chk("R9");
        tick(50); chk("R9");
    endtask

    // R10, R13: amplitude extremes
    task automatic t_amp();
        wr(16'h1f00, 16'h1f00);
        chk("R13");
        wr(16'h1f00, 16'h0000);
        chk("R10");
        check_val("R10", got_out(), nominal());
        wr(16'h1f00, 16'h0800);
    endtask

    // R4: restart holds and then starts from index 0
    task automatic t_restart();
        tick(10);
        wr(16'h0004, 16'h0004);
        chk("R4");
        tick(5); chk("R4");
        wr(16'h0004, 16'h0000);
        chk("R4");
        tick(2); chk("R4");
    endtask

    // R11, R8: fraction gating and another nominal value
    task automatic t_frac();
        fb_frac = 24'h000123;
        chk("R11");
        check_val("R11", got_out(), nominal());
        fb_frac = '0;
        fb_int  = 12'd2500;
        chk("R8");
        wr(16'h0008, 16'h0000);
        tick(17); chk("R8");
    endtask

    initial begin
        t_reset();
        t_config();
        t_center();
        t_wrap();
        t_bypass();
        t_rate();
        t_down();
        t_amp();
        t_restart();
        t_frac();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule